// File: doc/BRIEF.md
# SIMD Pack Unsigned Saturation Unit

This pipelined datapath narrows two packed vectors of signed 16-bit words into one packed vector of unsigned bytes. Every word is read as a two's-complement value and clamped into the range 0 to 255. Negative words become 0x00, words above 255 become 0xFF, and all other words pass through unchanged. Lanes of the first operand (`in_a`) fill the low bytes of the result and lanes of the second operand (`in_b`) fill the bytes above them.

A mode bit picks one of two widths. The narrow operation uses four words of each operand (the low 64 bits of each bus) and yields eight bytes. The wide operation uses eight words of each operand and yields sixteen bytes. Both modes share one eight-lane clamp array. A narrow operation goes through it once. A wide operation goes through it twice, first with the `in_a` words and then with the `in_b` words. This is why the wide mode can only issue every second cycle and has the longer latency.

Results always leave in the order the operations were accepted. `in_ready` holds back new requests during the slots in which they would collide with a wide operation that is still in flight. The block has no status or flag outputs.

Top module: `pack_usat_unit`

## Requirements
- R1: Each 16-bit word is signed. A word with bit 15 set gives 0x00, a word from 0x0100 to 0x7FFF gives 0xFF, and a word from 0x0000 to 0x00FF (0x00FF included) gives its low byte unchanged.
- R2: Narrow mode (`in_wide`=0). Word i of `in_a` (bits 16i+15:16i, i=0..3) gives result byte i (bits 8i+7:8i). Word i of `in_b` gives result byte 4+i. Bits 127:64 of both operands have no effect.
- R3: Wide mode (`in_wide`=1). Word i of `in_a` (i=0..7) gives result byte i, and word i of `in_b` gives result byte 8+i.
- R4: A narrow result drives `out_data` bits 127:64 to zero.
- R5: A narrow operation accepted at clock edge t (`in_valid` and `in_ready` both high) passes through two registers. `out_valid` and its data are present in the cycle after edge t+1.
- R6: A wide operation accepted at edge t passes through four registers. Its result is present in the cycle after edge t+3.
- R7: With no wide operation in the two preceding edges, `in_ready` is high, so narrow operations can be accepted on every edge.
- R8: In the cycle after a wide operation is accepted, `in_ready` is low whatever the mode of the pending request.
- R9: In the second cycle after a wide operation is accepted, `in_ready` is low for a narrow request and high for a wide request.
- R10: Each accepted operation produces exactly one `out_valid` cycle. Results appear in the order the operations were accepted. `out_valid` is low in every other cycle.
- R11: While `rst_n` is low, and after it is released before any operation, `out_valid` is low and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Request carries an operation |
| in_wide | input | 1 | 1 = eight words per operand, 0 = four words per operand |
| in_a | input | 128 | First operand, words fill the low result bytes |
| in_b | input | 128 | Second operand, words fill the upper result bytes |
| in_ready | output | 1 | Request is accepted at this edge when high together with in_valid |
| out_valid | output | 1 | out_data holds a result this cycle |
| out_data | output | 128 | Packed unsigned byte result |

## Verification
The hardest case to reach from the ports is a narrow request arriving exactly two cycles after a wide one. That is the only slot where its short path would land on the same output register as the wide result, so `in_ready` has to depend on the request's mode. Directed sequences place a wide, a narrow and another wide request at exactly those distances. Random traffic with a high valid rate and an even mix of modes then hits this slot many times, while a cycle-indexed scoreboard checks both the ordering and the exact latency. Word values are drawn from classes that sit on the clamp boundaries (0x00FF, 0x0100, 0x7FFF, 0x8000, 0xFFFF), so every lane position sees all three clamp outcomes.

// File: rtl/pus_pkg.sv
package pus_pkg;

   // control tag that travels with a result through the shared stages
   typedef struct packed {
      logic valid;
      logic wide;
   } pus_tag_t;

   localparam pus_tag_t PUS_TAG_IDLE = '{valid: 1'b0, wide: 1'b0};

endpackage

// File: rtl/pus_lane_clamp.sv
module pus_lane_clamp #(
   parameter int IN_W  = 16,
   parameter int OUT_W = 8
) (
   input  logic [IN_W-1:0]  word_i,
   output logic [OUT_W-1:0] byte_o
);

   localparam int EXTRA_W = IN_W - OUT_W - 1;

   generate
      if (OUT_W >= IN_W) begin : g_bad_width
         $error("pus_lane_clamp: OUT_W must be narrower than IN_W");
      end

      if (EXTRA_W == 0) begin : g_no_extra
         // only the sign bit lies above the byte
         always_comb begin
            if (word_i[IN_W-1]) byte_o = '0;
            else                byte_o = word_i[OUT_W-1:0];
         end
      end else begin : g_extra
         logic over;
         assign over = |word_i[IN_W-2:OUT_W];
         always_comb begin
            if (word_i[IN_W-1]) byte_o = '0;
            else if (over)      byte_o = '1;
            else                byte_o = word_i[OUT_W-1:0];
         end
      end
   endgenerate

endmodule

// File: rtl/pus_clamp_array.sv
module pus_clamp_array #(
   parameter int IN_W  = 16,
   parameter int OUT_W = 8,
   parameter int LANES = 8
) (
   input  logic [LANES*IN_W-1:0]  words_i,
   output logic [LANES*OUT_W-1:0] bytes_o
);

   generate
      if (LANES < 1) begin : g_bad_lanes
         $error("pus_clamp_array: LANES must be at least one");
      end

      for (genvar ln = 0; ln < LANES; ln++) begin : g_lane
         pus_lane_clamp #(
            .IN_W  (IN_W),
            .OUT_W (OUT_W)
         ) u_lane (
            .word_i (words_i[ln*IN_W +: IN_W]),
            .byte_o (bytes_o[ln*OUT_W +: OUT_W])
         );
      end
   endgenerate

endmodule

// File: rtl/pus_issue_ctrl.sv
module pus_issue_ctrl (
   input  logic clk,
   input  logic rst_n,
   input  logic req_valid,
   input  logic req_wide,
   input  logic wide_p1,      // wide op in its second clamp pass
   input  logic wide_p2,      // wide op about to enter the shared stage
   output logic ready,
   output logic take_narrow,
   output logic take_wide
);

   always_comb begin
      ready       = !wide_p1 && !(wide_p2 && !req_wide);
      take_narrow = req_valid && ready && !req_wide;
      take_wide   = req_valid && ready &&  req_wide;
   end

   // R8
   wide_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      take_wide |=> !ready);

   // R9
   narrow_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (take_wide ##1 1'b1) |=> (req_wide || !ready));

   // R7
   free_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!wide_p1 && !wide_p2) |-> ready);

endmodule

// File: rtl/pus_pipe.sv
module pus_pipe
   import pus_pkg::*;
#(
   parameter int ARR_W = 64,     // bytes out of one clamp pass, in bits
   parameter int BUS_W = 128
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             take_narrow,
   input  logic             take_wide,
   input  logic [ARR_W-1:0] clamp_bytes,
   input  logic [BUS_W-1:0] second_op,
   output logic             wide_p1,
   output logic             wide_p2,
   output logic [BUS_W-1:0] held_second,
   output logic             res_valid,
   output logic             res_wide,
   output logic [2*ARR_W-1:0] res_data
);

   localparam int RES_W = 2 * ARR_W;

   logic [ARR_W-1:0] lo_s1;
   logic [RES_W-1:0] res_s2, res_s3, res_s4;
   pus_tag_t         tag_s3, tag_s4;

   // control: stage 1 and 2 only ever carry wide operations
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wide_p1 <= 1'b0;
         wide_p2 <= 1'b0;
         tag_s3  <= PUS_TAG_IDLE;
         tag_s4  <= PUS_TAG_IDLE;
      end else begin
         wide_p1 <= take_wide;
         wide_p2 <= wide_p1;
         if (take_narrow)  tag_s3 <= '{valid: 1'b1, wide: 1'b0};
         else if (wide_p2) tag_s3 <= '{valid: 1'b1, wide: 1'b1};
         else              tag_s3 <= PUS_TAG_IDLE;
         tag_s4 <= tag_s3;
      end
   end

   // data: no reset, loaded only when a valid operation moves in
   always_ff @(posedge clk) begin
      if (take_wide) begin
         lo_s1       <= clamp_bytes;
         held_second <= second_op;
      end
      if (wide_p1)      res_s2 <= {clamp_bytes, lo_s1};
      if (take_narrow)  res_s3 <= {{ARR_W{1'b0}}, clamp_bytes};
      else if (wide_p2) res_s3 <= res_s2;
      if (tag_s3.valid) res_s4 <= res_s3;
   end

   assign res_valid = tag_s4.valid;
   assign res_wide  = tag_s4.wide;
   assign res_data  = res_s4;

   // R10
   merge_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
      take_narrow |-> !wide_p2);

   // R10
   single_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(take_narrow && take_wide));

   // R4
   narrow_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (res_valid && !res_wide) |-> (res_data[RES_W-1:ARR_W] == '0));

endmodule

// File: rtl/pack_usat_unit.sv
module pack_usat_unit #(
   parameter int WORD_W       = 16,
   parameter int BYTE_W       = 8,
   parameter int NARROW_WORDS = 4
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic                            in_valid,
   input  logic                            in_wide,
   input  logic [2*NARROW_WORDS*WORD_W-1:0] in_a,
   input  logic [2*NARROW_WORDS*WORD_W-1:0] in_b,
   output logic                            in_ready,
   output logic                            out_valid,
   output logic [4*NARROW_WORDS*BYTE_W-1:0] out_data
);

   localparam int WIDE_WORDS = 2 * NARROW_WORDS;
   localparam int BUS_W      = WIDE_WORDS * WORD_W;
   localparam int HALF_W     = NARROW_WORDS * WORD_W;
   localparam int ARR_W      = WIDE_WORDS * BYTE_W;
   localparam int RES_W      = 2 * ARR_W;

   generate
      if (NARROW_WORDS < 1) begin : g_bad_count
         $error("pack_usat_unit: NARROW_WORDS must be at least one");
      end
      if (BYTE_W >= WORD_W) begin : g_bad_byte
         $error("pack_usat_unit: BYTE_W must be narrower than WORD_W");
      end
   endgenerate

   logic             take_narrow, take_wide;
   logic             wide_p1, wide_p2;
   logic [BUS_W-1:0] held_second;
   logic [BUS_W-1:0] clamp_words;
   logic [ARR_W-1:0] clamp_bytes;
   logic             res_wide;

   pus_issue_ctrl u_ctrl (
      .clk         (clk),
      .rst_n       (rst_n),
      .req_valid   (in_valid),
      .req_wide    (in_wide),
      .wide_p1     (wide_p1),
      .wide_p2     (wide_p2),
      .ready       (in_ready),
      .take_narrow (take_narrow),
      .take_wide   (take_wide)
   );

   // clamp array input: second wide pass, first wide pass, or narrow pair
   always_comb begin
      if (wide_p1)      clamp_words = held_second;
      else if (in_wide) clamp_words = in_a;
      else              clamp_words = {in_b[HALF_W-1:0], in_a[HALF_W-1:0]};
   end

   pus_clamp_array #(
      .IN_W  (WORD_W),
      .OUT_W (BYTE_W),
      .LANES (WIDE_WORDS)
   ) u_clamp (
      .words_i (clamp_words),
      .bytes_o (clamp_bytes)
   );

   pus_pipe #(
      .ARR_W (ARR_W),
      .BUS_W (BUS_W)
   ) u_pipe (
      .clk         (clk),
      .rst_n       (rst_n),
      .take_narrow (take_narrow),
      .take_wide   (take_wide),
      .clamp_bytes (clamp_bytes),
      .second_op   (in_b),
      .wide_p1     (wide_p1),
      .wide_p2     (wide_p2),
      .held_second (held_second),
      .res_valid   (out_valid),
      .res_wide    (res_wide),
      .res_data    (out_data)
   );

   // R5
   narrow_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
      take_narrow |-> ##2 (out_valid && !res_wide));

   // R6
   wide_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
      take_wide |-> ##4 (out_valid && res_wide));

   // R1
   zero_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (take_narrow && (in_a[WORD_W-1:0] == '0)) |-> ##2 (out_data[BYTE_W-1:0] == '0));

endmodule

// File: tb/pack_usat_unit_bench.sv
module pack_usat_unit_bench;

   logic         clk = 1'b0;
   logic         rst_n;
   logic         in_valid, in_wide;
   logic [127:0] in_a, in_b;
   logic         in_ready, out_valid;
   logic [127:0] out_data;

   always #10 clk = ~clk;

   pack_usat_unit u_pack_usat_unit (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_valid  (in_valid),
      .in_wide   (in_wide),
      .in_a      (in_a),
      .in_b      (in_b),
      .in_ready  (in_ready),
      .out_valid (out_valid),
      .out_data  (out_data)
   );

   int total = 0;
   int bad   = 0;
   int ec    = 0;
   int last_wide = -100;
   bit done  = 1'b0;

   logic         exp_v [0:255];
   logic         exp_w [0:255];
   logic [127:0] exp_d [0:255];
   string        exp_t [0:255];

   always @(posedge clk) ec = ec + 1;

   function automatic logic [7:0] sat(input logic [15:0] w);
      if (w[15])          return 8'h00;
      if (w[14:8] != '0)  return 8'hFF;
      return w[7:0];
   endfunction

   function automatic logic [127:0] pack(input logic [127:0] a, input logic [127:0] b,
                                         input logic wide);
      logic [127:0] r = '0;
      int n = wide ? 8 : 4;
      for (int i = 0; i < n; i++) begin
         r[8*i +: 8]     = sat(a[16*i +: 16]);
         r[8*(n+i) +: 8] = sat(b[16*i +: 16]);
      end
      return r;
   endfunction

   function automatic logic [15:0] gen_word();
      case ($urandom % 7)
         0:       return 16'($urandom % 256);
         1:       return 16'h0100 + 16'($urandom % 16'h7F00);
         2:       return 16'h8000 | 16'($urandom);
         3:       return 16'h00FF;
         4:       return 16'h0100;
         5:       return (($urandom % 2) != 0) ? 16'h7FFF : 16'h8000;
         default: return 16'hFFFF;
      endcase
   endfunction

   function automatic logic [127:0] gen_bus();
      logic [127:0] v;
      for (int i = 0; i < 8; i++) v[16*i +: 16] = gen_word();
      return v;
   endfunction

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [127:0] act, input logic [127:0] expv);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, expv);
      end
   endtask

   task automatic check_out();
      int s = ec % 256;
      string t = exp_v[s] ? (exp_w[s] ? "R6" : "R5") : "R10";
      chk(out_valid == exp_v[s], t, "out_valid", 128'(out_valid), 128'(exp_v[s]));
      if (exp_v[s]) begin
         chk(out_data == exp_d[s], exp_t[s], "out_data", out_data, exp_d[s]);
         if (!exp_w[s])
            chk(out_data[127:64] == '0, "R4", "upper bytes", out_data, exp_d[s]);
      end
      exp_v[s] = 1'b0;
   endtask

   // one cycle: check outputs, drive a request, check ready, record acceptance
   task automatic step(input logic v, input logic w, input logic [127:0] a,
                       input logic [127:0] b, input string tag);
      bit rexp;
      string rt;
      int s;
      @(negedge clk);
      check_out();
      in_valid = v;
      in_wide  = w;
      in_a     = a;
      in_b     = b;
      #1;
      rexp = !(last_wide == ec) && !(last_wide == ec - 1 && !w);
      if (last_wide == ec)          rt = "R8";
      else if (last_wide == ec - 1) rt = "R9";
      else                          rt = "R7";
      chk(in_ready == rexp, rt, "in_ready", 128'(in_ready), 128'(rexp));
      if (v && rexp) begin
         s = (ec + (w ? 4 : 2)) % 256;
         exp_v[s] = 1'b1;
         exp_w[s] = w;
         exp_d[s] = pack(a, b, w);
         exp_t[s] = tag;
         if (w) last_wide = ec + 1;
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog expired actual=%0d expected=finished", ec);
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      logic [127:0] ca, cb;
      void'($urandom(32'd7331));
      for (int i = 0; i < 256; i++) begin
         exp_v[i] = 1'b0;
         exp_w[i] = 1'b0;
         exp_d[i] = '0;
         exp_t[i] = "R10";
      end
      rst_n = 1'b0;
      in_valid = 1'b0;
      in_wide = 1'b0;
      in_a = '0;
      in_b = '0;
      repeat (3) @(negedge clk);
      // R11 reset state
      chk(out_valid == 1'b0, "R11", "out_valid in reset", 128'(out_valid), 128'(0));
      chk(in_ready == 1'b1, "R11", "in_ready in reset", 128'(in_ready), 128'(1));
      rst_n = 1'b1;
      @(negedge clk);
      chk(out_valid == 1'b0, "R11", "out_valid after reset", 128'(out_valid), 128'(0));
      chk(in_ready == 1'b1, "R11", "in_ready after reset", 128'(in_ready), 128'(1));

      // R1 clamp corners in narrow mode; upper operand bits are garbage (R2)
      ca = {64'hDEAD_BEEF_8000_7FFF, 16'h7FFF, 16'h8000, 16'h0100, 16'h00FF};
      cb = {64'h0123_4567_89AB_CDEF, 16'h0001, 16'h0080, 16'h0000, 16'hFFFF};
      step(1, 0, ca, cb, "R1");
      // R1 clamp corners in wide mode
      ca = {16'h00FE, 16'h0101, 16'hFF00, 16'h00FF, 16'h7FFF, 16'h8000, 16'h0100, 16'h0000};
      cb = {16'h0001, 16'h0200, 16'h8001, 16'h0080, 16'hFFFF, 16'h00FF, 16'h0100, 16'h7F00};
      step(1, 1, ca, cb, "R1");
      repeat (5) step(0, 0, '0, '0, "R10");

      // R8 / R9: wide, then narrow requests held off twice, then accepted
      step(1, 1, gen_bus(), gen_bus(), "R3");
      step(1, 0, gen_bus(), gen_bus(), "R2");
      step(1, 0, gen_bus(), gen_bus(), "R2");
      step(1, 0, gen_bus(), gen_bus(), "R2");
      repeat (5) step(0, 0, '0, '0, "R10");

      // R9: wide every second cycle
      for (int i = 0; i < 4; i++) step(1, 1, gen_bus(), gen_bus(), "R3");
      // R7: back-to-back narrow
      for (int i = 0; i < 6; i++) step(1, 0, gen_bus(), gen_bus(), "R2");
      // narrow then wide, then narrow two cycles later (collision slot)
      step(1, 0, gen_bus(), gen_bus(), "R2");
      step(1, 1, gen_bus(), gen_bus(), "R3");
      step(0, 0, '0, '0, "R10");
      step(1, 0, gen_bus(), gen_bus(), "R2");
      step(1, 0, gen_bus(), gen_bus(), "R2");

      // random mixed traffic
      for (int i = 0; i < 4000; i++) begin
         logic w = 1'($urandom % 2);
         logic v = (($urandom % 10) < 8);
         step(v, w, gen_bus(), gen_bus(), w ? "R3" : "R2");
      end

      repeat (8) step(0, 0, '0, '0, "R10");
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule